// File: doc/BRIEF.md
# Square-Wave and Interrupt Output Controller

This block sits beside a real-time clock's timekeeping core and turns its alarm flags and reference tick into two active-low, open-drain-style pin levels. An 8-bit control register chooses what the pins carry. One pin is reserved for the first alarm's interrupt. The other pin is shared: it carries either a square wave at a rate software selects, or the second alarm's interrupt. The control register also holds an active-low oscillator enable, which is brought out as a run level for the analog oscillator.

The square wave comes from a free-running divider. The divider advances only on `ref_tick` pulses, and only while the oscillator is enabled. `ref_tick` is a one-cycle enable that pulses on every edge of the 32.768 kHz reference, which is 65,536 pulses per second. Alarm comparison, the serial bus and the oscillator itself live elsewhere. This block sees only a register write port, the two alarm flags and the tick.

Top module: `wave_irq_unit`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0x18: oscillator enabled, rate code 11, shared pin in square-wave mode, both interrupt enables clear. `osc_run` is 1 and both pins are released high.
- R2: A write stores bit 7 (oscillator stop), bits 4:3 (rate code), bit 2 (pin mode), bit 1 (alarm-2 enable) and bit 0 (alarm-1 enable). Bits 6 and 5 ignore writes, so `rd_data` equals the written byte AND 0x9F from the clock edge that takes the write.
- R3: `osc_run` is the inverse of control bit 7, and it follows a write at the same edge that updates `rd_data`.
- R4: The rate code sets how many `ref_tick` pulses each square-wave level lasts: 00 gives 32768 (1 Hz), 01 gives 8 (4.096 kHz), 10 gives 4 (8.192 kHz) and 11 gives 1 (32.768 kHz).
- R5: The divider counts only clock cycles that have `ref_tick` high while bit 7 is 0. While bit 7 is 1 the divider and the wave level are frozen, and they resume from the same point when bit 7 clears. The wave is low after reset.
- R6: A rate-code change leaves the level in progress at its old length. The new length applies from the next level change onward.
- R7: With bit 2 at 0, `wave_irq_n` carries the wave level one clock later, and `alm2_flag` has no effect on it.
- R8: With bit 2 at 1, `wave_irq_n` is driven low one clock after `alm2_flag` is high while bit 1 is set. Otherwise it is released high.
- R9: `irq1_n` is driven low one clock after `alm1_flag` is high while bit 0 is set. Otherwise it is released high. Bit 2 does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read-back value |
| ref_tick | input | 1 | One-cycle enable, one pulse per edge of the 32.768 kHz reference |
| alm1_flag | input | 1 | Alarm-1 match flag |
| alm2_flag | input | 1 | Alarm-2 match flag |
| osc_run | output | 1 | High while the oscillator should run |
| irq1_n | output | 1 | Alarm-1 interrupt pin level, active low |
| wave_irq_n | output | 1 | Shared pin level: square wave or alarm-2 interrupt, active low |

## Verification
The main test drives ticks on every cycle at the default rate, which shows that each level lasts one tick. It then drives ticks at 4.096 kHz and 8.192 kHz with the rate code rewritten partway through a level, which shows whether the length is reloaded only at a level change. Ticks with gaps and a stretch with the oscillator stopped show that the divider counts ticks and not clock cycles, and that it freezes in place. Alarm flags are toggled in both pin modes, with each enable set and clear, to tell the wave path from the interrupt path and a masked alarm from a live one. A long run at 1 Hz checks the full 32768-tick level.

// File: rtl/wiu_pkg.sv
package wiu_pkg;

    // Reference enable pulses per second (one per edge of 32.768 kHz)
    localparam int unsigned TICK_HZ = 65536;
    localparam int unsigned MAX_HALF = TICK_HZ / 2;
    localparam int unsigned DIV_W = $clog2(MAX_HALF);

    typedef enum logic [1:0] {
        RATE_1HZ  = 2'b00,
        RATE_4K   = 2'b01,
        RATE_8K   = 2'b10,
        RATE_32K  = 2'b11
    } rate_e;

    typedef struct packed {
        logic       osc_stop;
        logic [1:0] pad;
        rate_e      rate;
        logic       irq_mode;
        logic       en2;
        logic       en1;
    } ctrl_t;

    localparam logic [7:0] CTRL_RST  = 8'h18;
    localparam logic [7:0] CTRL_MASK = 8'h9F;

    typedef logic [DIV_W-1:0] div_t;

    // Last count value of one wave level for a given rate
    function automatic div_t level_last(rate_e r);
        int unsigned hz;
        case (r)
            RATE_1HZ: hz = 1;
            RATE_4K:  hz = 4096;
            RATE_8K:  hz = 8192;
            default:  hz = 32768;
        endcase
        return div_t'(TICK_HZ / (2 * hz) - 1);
    endfunction

endpackage

// File: rtl/wiu_ctrl_reg.sv
module wiu_ctrl_reg
    import wiu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctrl_t      ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= ctrl_t'(CTRL_RST);
        end else if (wr_en) begin
            ctrl <= ctrl_t'(wr_data & CTRL_MASK);
        end
    end

endmodule

// File: rtl/wiu_divider.sv
module wiu_divider
    import wiu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  run,
    input  rate_e rate,
    output logic  wave
);

    div_t cnt;
    div_t last;
    logic wrap;

    assign wrap = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            last <= level_last(RATE_32K);
            wave <= 1'b0;
        end else if (tick && run) begin
            if (wrap) begin
                cnt  <= '0;
                wave <= ~wave;
                last <= level_last(rate);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wiu_pin_mux.sv
module wiu_pin_mux
    import wiu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  wave,
    input  logic  alm1,
    input  logic  alm2,
    output logic  pin1_n,
    output logic  pin2_n
);

    logic nxt1_n;
    logic nxt2_n;

    always_comb begin
        nxt1_n = ~(alm1 & ctrl.en1);
        if (ctrl.irq_mode) begin
            nxt2_n = ~(alm2 & ctrl.en2);
        end else begin
            nxt2_n = wave;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin1_n <= 1'b1;
            pin2_n <= 1'b1;
        end else begin
            pin1_n <= nxt1_n;
            pin2_n <= nxt2_n;
        end
    end

endmodule

// File: rtl/wave_irq_unit.sv
module wave_irq_unit
    import wiu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       ref_tick,
    input  logic       alm1_flag,
    input  logic       alm2_flag,
    output logic       osc_run,
    output logic       irq1_n,
    output logic       wave_irq_n
);

    ctrl_t ctrl;
    logic  wave;

    wiu_ctrl_reg i_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    wiu_divider i_div (
        .clk  (clk),
        .rst  (rst),
        .tick (ref_tick),
        .run  (~ctrl.osc_stop),
        .rate (ctrl.rate),
        .wave (wave)
    );

    wiu_pin_mux i_mux (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl),
        .wave   (wave),
        .alm1   (alm1_flag),
        .alm2   (alm2_flag),
        .pin1_n (irq1_n),
        .pin2_n (wave_irq_n)
    );

    assign rd_data = ctrl;
    assign osc_run = ~ctrl.osc_stop;

endmodule

// File: rtl/wiu_checker.sv
module wiu_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       alm1_flag,
    input logic       alm2_flag,
    input logic       osc_run,
    input logic       irq1_n,
    input logic       wave_irq_n
);

    AST_WRITE_MASKED: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == ($past(wr_data) & 8'h9F));  // R2

    AST_OSC_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> osc_run == !$past(wr_data[7]));  // R3

    AST_WAVE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (rd_data[7] && $past(rd_data[7]) && !rd_data[2] && !$past(rd_data[2]))
        |=> $stable(wave_irq_n));  // R5

    AST_SHARED_IRQ: assert property (@(posedge clk) disable iff (rst)
        rd_data[2] |=> wave_irq_n == !($past(alm2_flag) && $past(rd_data[1])));  // R8

    AST_DEDICATED_IRQ: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq1_n == !($past(alm1_flag) && $past(rd_data[0])));  // R9

endmodule

bind wave_irq_unit wiu_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .alm1_flag  (alm1_flag),
    .alm2_flag  (alm2_flag),
    .osc_run    (osc_run),
    .irq1_n     (irq1_n),
    .wave_irq_n (wave_irq_n)
);

// File: tb/test_wave_irq_unit.sv
module test_wave_irq_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ref_tick = 1'b0;
    logic       alm1_flag = 1'b0;
    logic       alm2_flag = 1'b0;
    logic       osc_run;
    logic       irq1_n;
    logic       wave_irq_n;

    always #5 clk = ~clk;

    wave_irq_unit i_wave_irq_unit (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .ref_tick   (ref_tick),
        .alm1_flag  (alm1_flag),
        .alm2_flag  (alm2_flag),
        .osc_run    (osc_run),
        .irq1_n     (irq1_n),
        .wave_irq_n (wave_irq_n)
    );

    typedef struct {
        logic       p1;
        logic       p2;
        logic       run;
        logic [7:0] rd;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // Reference model state (from the requirements)
    logic [7:0] m_ctrl = 8'h18;
    int         m_cnt  = 0;
    int         m_len  = 1;
    logic       m_wave = 1'b0;

    // R4: ticks per level for each rate code
    function automatic int level_len(logic [1:0] code);
        case (code)
            2'b00:   return 32768;
            2'b01:   return 8;
            2'b10:   return 4;
            default: return 1;
        endcase
    endfunction

    // Monitor: compare everything queued at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            n_vec++;
            if (irq1_n !== e.p1 || wave_irq_n !== e.p2 ||
                osc_run !== e.run || rd_data !== e.rd) begin
                n_bad++;
                $display("FAIL %s: got irq1_n=%b wave_irq_n=%b osc_run=%b rd=%h expected %b %b %b %h",
                         e.tag, irq1_n, wave_irq_n, osc_run, rd_data,
                         e.p1, e.p2, e.run, e.rd);
            end
        end
    end

    // Driver: one clock cycle of stimulus, then push the expected result
    task automatic step(input logic tk, input logic a1, input logic a2,
                        input logic we, input logic [7:0] wd, input string tag);
        item_t e;
        logic  n1;
        logic  n2;
        @(negedge clk);
        ref_tick  = tk;
        alm1_flag = a1;
        alm2_flag = a2;
        wr_en     = we;
        wr_data   = wd;
        @(posedge clk);
        n1 = !(a1 && m_ctrl[0]);
        n2 = m_ctrl[2] ? !(a2 && m_ctrl[1]) : m_wave;
        if (tk && !m_ctrl[7]) begin
            m_cnt++;
            if (m_cnt == m_len) begin
                m_cnt  = 0;
                m_wave = !m_wave;
                m_len  = level_len(m_ctrl[4:3]);
            end
        end
        if (we) m_ctrl = wd & 8'h9F;
        e.p1 = n1; e.p2 = n2; e.run = !m_ctrl[7]; e.rd = m_ctrl; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr(input logic [7:0] v, input string tag);
        step(1'b0, 1'b0, 1'b0, 1'b1, v, tag);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, tag);
    endtask

    task automatic ticks(input int n, input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, tag);
            for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, tag);
        end
    endtask

    initial begin
        item_t e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        e.p1 = 1'b1; e.p2 = 1'b1; e.run = 1'b1; e.rd = 8'h18; e.tag = "R1 reset";
        q.push_back(e);
        @(negedge clk);
        rst = 1'b0;

        // R4 R7: default rate, one tick per level
        ticks(8, 0, "R4 R7 rate11");
        // R5: ticks with gaps count only ticks
        ticks(6, 2, "R5 gapped ticks");

        // R2 R3 R8 R9: all bits written, oscillator stopped, interrupt mode
        wr(8'hFF, "R2 R3 write FF");
        for (int i = 0; i < 4; i++) begin
            step(1'b1, i[0], i[1], 1'b0, 8'h00, "R8 R9 alarms enabled");
        end
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8 R9 alarms clear");

        // R8 R9: enables clear, alarms masked
        wr(8'h04, "R2 write 04");
        for (int i = 0; i < 4; i++) begin
            step(1'b0, i[0], i[1], 1'b0, 8'h00, "R8 R9 masked");
        end

        // R4 R7 R9: 4.096 kHz, alarm-2 ignored in wave mode, alarm-1 masked
        wr(8'h08, "R2 write 08");
        for (int i = 0; i < 40; i++) begin
            step(1'b1, i[1], i[0], 1'b0, 8'h00, "R4 R7 rate01");
        end
        // R6: switch to 8.192 kHz in the middle of a level
        ticks(3, 0, "R6 before change");
        wr(8'h10, "R6 write 10");
        ticks(30, 0, "R6 rate10");

        // R5: stop oscillator, ticks frozen, then resume
        wr(8'h90, "R3 stop");
        ticks(10, 0, "R5 frozen");
        wr(8'h12, "R3 resume");
        ticks(9, 1, "R5 resumed");

        // R9 in wave mode, R4 at 1 Hz
        wr(8'h01, "R2 write 01");
        step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R9 wave mode alarm1");
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R9 wave mode clear");
        ticks(66000, 0, "R4 rate00");
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R4 final");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule